// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog for a system chip. A free-running counter advances on a slow tick enable. Once the watchdog is on, software must issue a kick before the selected period runs out. If no kick arrives in time, the block raises a one-cycle system reset request. The timeout period is chosen by a four-bit code, and each step of the code doubles the period.

The control register is written over a simple byte-wide write bus. Its enable bit and its period field are shielded, so a runaway program cannot rewrite them by accident. A change is accepted only inside a short window that an unlock write opens. There are two build-time variants. In the default one, the unlock is a control write with the change and enable bits both set. In the other, the unlock is a signature byte written to a separate protection address.

A sticky flag records watchdog resets, and the watchdog cannot be switched off while that flag is set. A strap input keeps the watchdog permanently on. Any warm reset, and any reset the watchdog itself causes, leaves the watchdog running at its shortest period. Only the power-on reset turns it off.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset the control readback is 0x00, the reset flag is 0 and the reset request is low.
- R2: While on, the block counts tick enables. On the tick that completes BASE_TICKS << code counts without a kick, it drives `wdResetReq` high for exactly one cycle, in the cycle after that edge.
- R3: A kick clears the count, so the next timeout needs a full period of ticks after the kick. A kick in the same cycle as the final tick prevents that timeout.
- R4: Each step of the period code doubles the period. Codes 8 and 9 give 256x and 512x the base. Codes above 9 behave as 9, but the value written is still stored.
- R5: Control readback at address 0: bit 5 is code bit 3, bit 4 is the open-window flag, bit 3 is the effective enable, bits 2:0 are code bits 2:0, and bits 7:6 read 0.
- R6: In the default variant, a control write with bits 4 and 3 both set opens a window and changes nothing else. A control write on any of the next 4 clock edges is applied. If no write arrives by the 4th edge, the window flag clears by itself.
- R7: A control write made while no window is open leaves both the enable and the period unchanged.
- R8: An unlock write followed by a 0x00 write inside the window switches the watchdog off, and it then requests no resets.
- R9: Each reset request sets the flag, read at status address 1 bit 0. Writing 0 to that bit clears it, and writing 1 has no effect.
- R10: While the flag is set, an applied write with the enable bit at 0 keeps the watchdog on. The period from that write is still taken.
- R11: While `forceOn` is high, the watchdog is on and counting, and an applied disable write does not stop it. When the strap drops, the stored enable shows through again.
- R12: A warm reset, or a watchdog reset request, leaves the watchdog on with code 0, closes any open window and leaves the flag unchanged.
- R13: With SIG_UNLOCK=1, only the byte 0xD8 written to address 2 opens the window. In that variant a control write of 0x18 opens nothing, and other bytes at address 2 open nothing.
- R14: An applied configuration write restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, asynchronous, active low |
| warmRst | input | 1 | Synchronous non-power-on reset, active high |
| tickEn | input | 1 | Slow tick enable that advances the counter |
| kick | input | 1 | Restart the count (one cycle per kick) |
| forceOn | input | 1 | Strap that keeps the watchdog on |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 control, 1 status, 2 protection signature |
| wrData | input | 8 | Write data |
| rdCtrl | output | 8 | Control register readback |
| wdFlag | output | 1 | Watchdog reset flag |
| wdResetReq | output | 1 | One-cycle system reset request |

## Verification
A kick can land on the same clock edge as the tick that would complete the period. The bench provokes this on purpose by raising `kick` on exactly that edge, and requires that no reset request follows and that a full new period must then elapse (R3). A random phase, with a fixed seed, mixes tick enables and kicks so that these collisions recur many times, including right after a timeout has dropped the code to 0. A bench model compares `wdResetReq` on every cycle. The unlock window is probed on its last accepted edge and on the first rejected one.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 9;
  localparam int BIT_P3   = 5;
  localparam int BIT_CHG  = 4;
  localparam int BIT_EN   = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_SIG  = 2'd2;

  typedef struct packed {
    logic              clrCnt;
    logic              wdOn;
    logic [CODE_W-1:0] periodCode;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_guard_pkg::*;
#(
  parameter int         WIN_CYCLES = 4,
  parameter int         SIG_UNLOCK = 0,
  parameter logic [7:0] SIG_BYTE   = 8'hD8
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       closeNow,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       winOpen,
  output logic       applyHit
);
  localparam int WL_W = $clog2(WIN_CYCLES + 1);

  logic [WL_W-1:0] winLeft;
  logic            reopen;
  logic            unusedData;

  assign unusedData = ^wrData;

  generate
    if (SIG_UNLOCK != 0) begin : g_sig
      assign reopen = wrEn && (wrAddr == ADDR_SIG) && (wrData == SIG_BYTE);
    end else begin : g_chg
      assign reopen = wrEn && (wrAddr == ADDR_CTRL) && wrData[BIT_CHG] && wrData[BIT_EN];
    end
  endgenerate

  assign winOpen  = (winLeft != '0);
  assign applyHit = wrEn && (wrAddr == ADDR_CTRL) && winOpen && !reopen && !closeNow;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)       winLeft <= '0;
    else if (closeNow)  winLeft <= '0;
    else if (reopen)    winLeft <= WL_W'(WIN_CYCLES);
    else if (applyHit)  winLeft <= '0;
    else if (winOpen)   winLeft <= winLeft - 1'b1;
  end

  // R6: an open window with no bus traffic loses one cycle per edge
  p_window_shrinks_r6: assert property (@(posedge clk) disable iff (!rstPorN)
    (winOpen && !wrEn && !closeNow) |=> (winLeft == $past(winLeft) - 1'b1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int         WIN_CYCLES = 4,
  parameter int         SIG_UNLOCK = 0,
  parameter logic [7:0] SIG_BYTE   = 8'hD8
) (
  input  logic        clk,
  input  logic        rstPorN,
  input  logic        warmRst,
  input  logic        kick,
  input  logic        forceOn,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        resetReq,
  output wdt_strobe_t strobe,
  output logic [7:0]  rdCtrl,
  output logic        wdFlag
);
  logic              enBit;
  logic [CODE_W-1:0] periodCode;
  logic              flagQ;
  logic              winOpen;
  logic              applyHit;
  logic              forceSafe;
  logic              statWr;
  logic              unusedCtrlBits;

  assign forceSafe      = warmRst || resetReq;
  assign statWr         = wrEn && (wrAddr == ADDR_STAT);
  assign unusedCtrlBits = ^{wrData[7:6], wrData[BIT_CHG]};

  wdt_unlock #(
    .WIN_CYCLES(WIN_CYCLES),
    .SIG_UNLOCK(SIG_UNLOCK),
    .SIG_BYTE  (SIG_BYTE)
  ) u_unlock (
    .clk     (clk),
    .rstPorN (rstPorN),
    .closeNow(forceSafe),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .winOpen (winOpen),
    .applyHit(applyHit)
  );

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      enBit      <= 1'b0;
      periodCode <= '0;
    end else if (forceSafe) begin
      enBit      <= 1'b1;
      periodCode <= '0;
    end else if (applyHit) begin
      enBit      <= wrData[BIT_EN] | (enBit & flagQ);
      periodCode <= {wrData[BIT_P3], wrData[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)                    flagQ <= 1'b0;
    else if (resetReq)               flagQ <= 1'b1;
    else if (statWr && !wrData[0])   flagQ <= 1'b0;
  end

  always_comb begin
    strobe.wdOn       = enBit | forceOn;
    strobe.periodCode = periodCode;
    strobe.clrCnt     = kick | applyHit | warmRst;
  end

  assign rdCtrl = {2'b00, periodCode[3], winOpen, strobe.wdOn, periodCode[2:0]};
  assign wdFlag = flagQ;

  // R7: locked configuration survives control writes outside a window
  p_locked_cfg_r7: assert property (@(posedge clk) disable iff (!rstPorN)
    (wrEn && (wrAddr == ADDR_CTRL) && !winOpen && !forceSafe)
      |=> ($stable(enBit) && $stable(periodCode)));
  // R10: a set flag keeps the stored enable on
  p_flag_holds_enable_r10: assert property (@(posedge clk) disable iff (!rstPorN)
    (flagQ && enBit) |=> enBit);
  // R9: every reset request leaves the flag set
  p_flag_on_request_r9: assert property (@(posedge clk) disable iff (!rstPorN)
    resetReq |=> flagQ);
  // R12: after a warm or watchdog reset the block is on, shortest, window shut
  p_safe_state_r12: assert property (@(posedge clk) disable iff (!rstPorN)
    forceSafe |=> (enBit && (periodCode == '0) && !winOpen));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_guard_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstPorN,
  input  logic        tickEn,
  input  wdt_strobe_t strobe,
  output logic        resetReq
);
  localparam int CNT_W = $clog2(BASE_TICKS << MAX_CODE) + 1;

  function automatic logic [CNT_W-1:0] tickLimit(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] eff;
    eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    return CNT_W'(BASE_TICKS) << eff;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             reqQ;
  logic             atEnd;

  assign limit = tickLimit(strobe.periodCode);
  assign atEnd = (cnt >= limit - 1'b1);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      cnt  <= '0;
      reqQ <= 1'b0;
    end else begin
      reqQ <= 1'b0;
      if (!strobe.wdOn || strobe.clrCnt) begin
        cnt <= '0;
      end else if (tickEn) begin
        if (atEnd) begin
          cnt  <= '0;
          reqQ <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign resetReq = reqQ;

  // R2: the request is a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    reqQ |=> !reqQ);
  // R2: no request can follow an edge without a tick
  p_req_needs_tick_r2: assert property (@(posedge clk) disable iff (!rstPorN)
    !tickEn |=> !reqQ);
  // R3: a kick empties the counter and suppresses the request
  p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rstPorN)
    strobe.clrCnt |=> ((cnt == '0) && !reqQ));
  // R8: a watchdog that is off never counts
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rstPorN)
    !strobe.wdOn |=> ((cnt == '0) && !reqQ));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int         BASE_TICKS = 4,
  parameter int         WIN_CYCLES = 4,
  parameter int         SIG_UNLOCK = 0,
  parameter logic [7:0] SIG_BYTE   = 8'hD8
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       warmRst,
  input  logic       tickEn,
  input  logic       kick,
  input  logic       forceOn,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdCtrl,
  output logic       wdFlag,
  output logic       wdResetReq
);
  wdt_strobe_t strobe;
  logic        resetReq;

  wdt_ctrl #(
    .WIN_CYCLES(WIN_CYCLES),
    .SIG_UNLOCK(SIG_UNLOCK),
    .SIG_BYTE  (SIG_BYTE)
  ) u_ctrl (
    .clk     (clk),
    .rstPorN (rstPorN),
    .warmRst (warmRst),
    .kick    (kick),
    .forceOn (forceOn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .resetReq(resetReq),
    .strobe  (strobe),
    .rdCtrl  (rdCtrl),
    .wdFlag  (wdFlag)
  );

  wdt_datapath #(
    .BASE_TICKS(BASE_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstPorN (rstPorN),
    .tickEn  (tickEn),
    .strobe  (strobe),
    .resetReq(resetReq)
  );

  assign wdResetReq = resetReq;
endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rstPorN, warmRst, tickEn, kick, forceOn, wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] rdCtrl, rdCtrlS;
  logic       wdFlag, wdFlagS, wdResetReq, wdResetReqS;

  int nRun  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  wdt_guard #(.BASE_TICKS(BASE)) i_wdt_guard (
    .clk(clk), .rstPorN(rstPorN), .warmRst(warmRst), .tickEn(tickEn), .kick(kick),
    .forceOn(forceOn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdCtrl(rdCtrl), .wdFlag(wdFlag), .wdResetReq(wdResetReq));

  wdt_guard #(.BASE_TICKS(BASE), .SIG_UNLOCK(1)) i_wdt_guard_sig (
    .clk(clk), .rstPorN(rstPorN), .warmRst(warmRst), .tickEn(tickEn), .kick(kick),
    .forceOn(forceOn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdCtrl(rdCtrlS), .wdFlag(wdFlagS), .wdResetReq(wdResetReqS));

  function automatic int limOf(input int code);
    return BASE << ((code > 9) ? 9 : code);
  endfunction

  function automatic logic [7:0] cfgByte(input logic [3:0] code);
    return {2'b00, code[3], 1'b0, 1'b1, code[2:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] code);
    kick = 1'b1;
    idle(2);
    wr(2'd0, 8'h18);
    wr(2'd0, cfgByte(code));
    kick = 1'b0;
  endtask

  task automatic firstReq(input int maxN, output int nAt);
    nAt = -1;
    for (int n = 1; n <= maxN; n++) begin
      @(negedge clk);
      if (wdResetReq) begin
        nAt = n;
        break;
      end
    end
  endtask

  task automatic porPulse();
    rstPorN = 1'b0;
    idle(2);
    rstPorN = 1'b1;
    idle(1);
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int nAt;
    int seedDummy;
    logic flagBefore;
    seedDummy = $urandom(32'h5eed);
    rstPorN = 1'b0; warmRst = 1'b0; tickEn = 1'b0; kick = 1'b0;
    forceOn = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    idle(3);
    rstPorN = 1'b1;
    idle(1);

    // R1 power-on state
    chk("R1 ctrl", rdCtrl, 8'h00);
    chk("R1 flag", wdFlag, 1'b0);
    chk("R1 req", wdResetReq, 1'b0);
    chk("R1 ctrl sig", rdCtrlS, 8'h00);

    // R13 / R6 / R7: unlock variants side by side
    wr(2'd0, 8'h18);
    chk("R6 unlock opens only", rdCtrl, 8'h10);
    chk("R13 ctrl unlock ignored", rdCtrlS, 8'h00);
    idle(5);
    chk("R6 window self-clears", rdCtrl, 8'h00);
    wr(2'd2, 8'hD8);
    chk("R13 signature opens", rdCtrlS, 8'h10);
    wr(2'd0, 8'h0B);
    chk("R13 applied after signature", rdCtrlS, 8'h0B);
    chk("R7 no window ignored", rdCtrl, 8'h00);
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h00);
    chk("R13 wrong signature", rdCtrlS, 8'h0B);
    porPulse();

    // R6 window boundary: 4th edge accepted, 5th rejected
    wr(2'd0, 8'h18);
    idle(3);
    wr(2'd0, 8'h0A);
    chk("R6 last edge accepted", rdCtrl, 8'h0A);
    wr(2'd0, 8'h18);
    idle(4);
    chk("R6 flag cleared after window", rdCtrl, 8'h0A);
    wr(2'd0, 8'h0D);
    chk("R7 late write ignored", rdCtrl, 8'h0A);

    // R8 disable sequence
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h00);
    chk("R8 disabled", rdCtrl, 8'h00);

    // R2 / R4 / R5 / R9 / R12 timeout per period code
    tickEn = 1'b1;
    foreach (codeList[i]) begin
      cfg(codeList[i]);
      chk("R5 readback", rdCtrl, cfgByte(codeList[i]));
      firstReq(limOf(codeList[i]) + 2, nAt);
      chk("R2 R4 timeout cycle", nAt, limOf(codeList[i]));
      @(negedge clk);
      chk("R2 single pulse", wdResetReq, 1'b0);
      chk("R12 shortest after timeout", rdCtrl, 8'h08);
      chk("R9 flag set", wdFlag, 1'b1);
    end

    // R3 kick restarts
    cfg(4'd2);
    idle(5);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    firstReq(10, nAt);
    chk("R3 full period after kick", nAt, 8);

    // R3 kick on the final tick
    cfg(4'd1);
    idle(3);
    kick = 1'b1;
    @(negedge clk);
    chk("R3 kick beats final tick", wdResetReq, 1'b0);
    kick = 1'b0;
    firstReq(6, nAt);
    chk("R3 next timeout", nAt, 4);

    // R14 applied write restarts count
    cfg(4'd2);
    idle(4);
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h0A);
    firstReq(10, nAt);
    chk("R14 restart on apply", nAt, 8);

    // R10 / R9 flag gating the disable
    kick = 1'b1;
    idle(2);
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h00);
    chk("R10 disable blocked", rdCtrl, 8'h08);
    wr(2'd1, 8'h01);
    chk("R9 write one no effect", wdFlag, 1'b1);
    wr(2'd1, 8'h00);
    chk("R9 write zero clears", wdFlag, 1'b0);
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h00);
    chk("R8 disable after clear", rdCtrl, 8'h00);
    kick = 1'b0;
    firstReq(20, nAt);
    chk("R8 no request when off", nAt, 32'hFFFFFFFF);

    // R11 strap
    forceOn = 1'b1;
    @(negedge clk);
    chk("R11 forced on", rdCtrl, 8'h08);
    firstReq(6, nAt);
    chk("R11 counting when forced", nAt, 1);
    kick = 1'b1;
    idle(2);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h18);
    wr(2'd0, 8'h00);
    chk("R11 disable has no effect", rdCtrl, 8'h08);
    forceOn = 1'b0;
    @(negedge clk);
    chk("R11 stored enable shows", rdCtrl, 8'h00);
    kick = 1'b0;

    // R12 warm reset
    cfg(4'd5);
    kick = 1'b1;
    idle(1);
    chk("R12 setup", rdCtrl, 8'h0D);
    wr(2'd0, 8'h18);
    flagBefore = wdFlag;
    warmRst = 1'b1;
    @(negedge clk);
    warmRst = 1'b0;
    chk("R12 warm reset state", rdCtrl, 8'h08);
    chk("R12 flag untouched", wdFlag, flagBefore);

    // R2 / R3 random ticks and kicks against a cycle model
    for (int trial = 0; trial < 6; trial++) begin
      int mCode, mCnt;
      logic mReq;
      mCode = $urandom % 3;
      cfg(4'(mCode));
      mCnt = 0; mReq = 1'b0;
      for (int c = 0; c < 400; c++) begin
        logic t, k, nReq;
        int lim;
        t = ($urandom % 2) == 0;
        k = ($urandom % 6) == 0;
        tickEn = t; kick = k;
        @(negedge clk);
        lim  = limOf(mCode);
        nReq = !k && t && (mCnt >= lim - 1);
        if (k) mCnt = 0;
        else if (t) mCnt = (mCnt >= lim - 1) ? 0 : mCnt + 1;
        if (mReq) mCode = 0;
        mReq = nReq;
        chk("R3 random request", wdResetReq, mReq);
      end
      tickEn = 1'b1; kick = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  logic [3:0] codeList [6] = '{4'd0, 4'd1, 4'd3, 4'd8, 4'd9, 4'd12};
endmodule